// File: doc/BRIEF.md
# Register Scoreboard Wakeup Unit

This block sits beside an instruction issue queue and works out, for every queue slot, whether all of that slot's source operands are available. It keeps one ready bit per physical register. It also keeps a small content-addressable record of which source tags each waiting slot still needs. When an instruction enters the queue, its destination register is marked not ready. Each source is then settled: it is ready at once if the sender already flagged it ready, if the scoreboard shows it ready, or if the producer is completing in that very cycle. Otherwise the slot records that it waits on that tag.

When a producer completes, its destination tag is broadcast to every slot in the same cycle. Every matching waiting operand becomes ready and the scoreboard bit is set. Tags numbered at or above the physical register count stand for registers that are not renamed, and the block never tracks them. Slots that hold memory operations report readiness on a separate vector meant for the memory-ordering logic, not on the issue-candidate vector. Reallocating a register while consumers still wait on its previous producer is an error, and the block flags it.

Top module: `sbw_wakeup_unit`

## Requirements
- R1: After reset every scoreboard bit reads ready, no slot is occupied, and `issueReady`, `memRegsReady` and `dupErr` are all zero. A slot inserted right after reset with in-range sources is ready.
- R2: An insert whose destination is in use and in range clears that register's scoreboard bit. A later consumer of that tag waits.
- R3: At insert, a used source is ready when its sender-ready flag is 1, or when the scoreboard bit of its tag is set at that time.
- R4: A completion with an in-range tag makes ready, in the following cycle, every waiting operand carrying that tag. Operands waiting on other tags stay waiting. A ready slot stays ready until it is squashed or overwritten.
- R5: A source that is inserted in the same cycle as the completion of its tag is ready without a further completion.
- R6: A tag at or above NUM_PREGS (40 by default) is ignored. As a source it counts as ready. As a destination it clears nothing and raises no error. As a completion it wakes nothing.
- R7: An insert whose in-range destination tag is still awaited by another occupied slot sets `dupErr` for exactly one cycle, starting with the clock edge that takes the insert. An insert with no such waiter leaves `dupErr` at 0.
- R8: A squash frees its slot: both outputs of the slot read 0 from the next cycle on, a later completion does not revive it, and its pending dependence no longer counts for R7. When an insert and a squash hit the same slot, the insert wins.
- R9: An occupied slot whose sources are all ready drives its bit in `memRegsReady` when it was inserted with `insIsMem`=1, and its bit in `issueReady` otherwise. It never drives both.
- R10: A source slot inserted with its use bit at 0 counts as ready, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| insValid | input | 1 | Insert an instruction into slot `insIdx` |
| insIdx | input | IDX_W | Target slot of the insert |
| insSrc0Use | input | 1 | First source is used |
| insSrc0Tag | input | TAG_W | First source register tag |
| insSrc0Rdy | input | 1 | First source already known ready by the sender |
| insSrc1Use | input | 1 | Second source is used |
| insSrc1Tag | input | TAG_W | Second source register tag |
| insSrc1Rdy | input | 1 | Second source already known ready by the sender |
| insDstUse | input | 1 | Instruction writes a destination register |
| insDstTag | input | TAG_W | Destination register tag |
| insIsMem | input | 1 | Instruction is a memory operation |
| cmpValid | input | 1 | A producer completes this cycle |
| cmpTag | input | TAG_W | Destination tag of the completing producer |
| sqValid | input | 1 | Squash slot `sqIdx` |
| sqIdx | input | IDX_W | Slot to squash |
| issueReady | output | NUM_ENTRIES | Per-slot all-operands-ready, non-memory slots |
| memRegsReady | output | NUM_ENTRIES | Per-slot all-operands-ready, memory slots |
| dupErr | output | 1 | One-cycle flag: destination reallocated while still awaited |

## Verification
The bench goes after the same-cycle race between a consumer insert and its producer's completion. A design that reads only the registered scoreboard would leave that consumer waiting forever. It also checks that one completion wakes exactly the operands with a matching tag, so a slot that waits on two tags stays waiting after the first wakeup; a design that woke whole slots would issue it too early. Out-of-range tags are used as sources, destinations and completions, which catches a design that clears or sets a scoreboard bit through a truncated index. Squashed slots are checked for staying dead through a later completion and for no longer counting toward the duplicate-producer flag; a design that skipped the cleanup would revive the slot or raise a false error.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  localparam int NUM_SRC = 2;

  // Strobes the decode stage hands to the datapath each cycle.
  typedef struct packed {
    logic               insEn;     // write the selected slot
    logic               insMem;    // slot holds a memory operation
    logic               dstTrack;  // destination is a tracked register
    logic               cmpTrack;  // completion tag is a tracked register
    logic [NUM_SRC-1:0] srcTrack;  // source needs a scoreboard lookup
  } sbwStrobes_t;

endpackage

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
  import sbw_pkg::*;
#(
  parameter int NUM_PREGS   = 40,
  parameter int TAG_W       = 6,
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                            insValid,
  input  logic [IDX_W-1:0]                insIdx,
  input  logic [NUM_SRC-1:0]              srcUse,
  input  logic [NUM_SRC-1:0]              srcRdy,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]   srcTag,
  input  logic                            insDstUse,
  input  logic [TAG_W-1:0]                insDstTag,
  input  logic                            insIsMem,
  input  logic                            cmpValid,
  input  logic [TAG_W-1:0]                cmpTag,
  input  logic                            sqValid,
  input  logic [IDX_W-1:0]                sqIdx,
  output sbwStrobes_t                     strobes,
  output logic [NUM_ENTRIES-1:0]          insSel,
  output logic [NUM_ENTRIES-1:0]          sqSel
);

  localparam logic [TAG_W:0] TAG_LIMIT = (TAG_W+1)'(NUM_PREGS);

  function automatic logic inRange(input logic [TAG_W-1:0] t);
    return ({1'b0, t} < TAG_LIMIT);
  endfunction

  always_comb begin
    strobes          = '0;
    strobes.insEn    = insValid;
    strobes.insMem   = insValid & insIsMem;
    strobes.dstTrack = insValid & insDstUse & inRange(insDstTag);
    strobes.cmpTrack = cmpValid & inRange(cmpTag);
    for (int k = 0; k < NUM_SRC; k++) begin
      strobes.srcTrack[k] = insValid & srcUse[k] & ~srcRdy[k] & inRange(srcTag[k]);
    end
  end

  // Slot decode; an insert on the same slot overrides a squash.
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_sel
    assign insSel[i] = insValid & (insIdx == IDX_W'(i));
    assign sqSel[i]  = sqValid & (sqIdx == IDX_W'(i)) & ~insSel[i];
  end

endmodule

// File: rtl/sbw_datapath.sv
module sbw_datapath
  import sbw_pkg::*;
#(
  parameter int NUM_PREGS   = 40,
  parameter int TAG_W       = 6,
  parameter int NUM_ENTRIES = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  sbwStrobes_t                     strobes,
  input  logic [NUM_ENTRIES-1:0]          insSel,
  input  logic [NUM_ENTRIES-1:0]          sqSel,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]   srcTag,
  input  logic [TAG_W-1:0]                insDstTag,
  input  logic [TAG_W-1:0]                cmpTag,
  output logic [NUM_ENTRIES-1:0]          issueReady,
  output logic [NUM_ENTRIES-1:0]          memRegsReady,
  output logic                            dupErr
);

  logic [NUM_PREGS-1:0]                          sbReady;
  logic [NUM_ENTRIES-1:0]                        entValid;
  logic [NUM_ENTRIES-1:0]                        entMem;
  logic [NUM_ENTRIES-1:0][NUM_SRC-1:0]           entWait;
  logic [NUM_ENTRIES-1:0][NUM_SRC-1:0][TAG_W-1:0] entTag;
  logic [NUM_ENTRIES-1:0][NUM_SRC-1:0]           wakeHit;
  logic [NUM_SRC-1:0]                            insWait;
  logic                                          dupNow;
  logic                                          dupQ;

  function automatic logic sbLookup(input logic [NUM_PREGS-1:0] sb,
                                    input logic [TAG_W-1:0] t);
    logic res;
    res = 1'b1;
    for (int r = 0; r < NUM_PREGS; r++) begin
      if (t == TAG_W'(r)) res = sb[r];
    end
    return res;
  endfunction

  // Source settlement at insert: scoreboard, plus same-cycle completion bypass.
  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      insWait[k] = strobes.srcTrack[k]
                 & ~sbLookup(sbReady, srcTag[k])
                 & ~(strobes.cmpTrack & (cmpTag == srcTag[k]));
    end
  end

  // Parallel tag broadcast against every waiting operand.
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cam
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      assign wakeHit[i][k] = entValid[i] & entWait[i][k] & strobes.cmpTrack
                           & (entTag[i][k] == cmpTag);
    end
  end

  // Reallocation of a destination that surviving slots still wait on.
  always_comb begin
    dupNow = 1'b0;
    if (strobes.dstTrack) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        for (int k = 0; k < NUM_SRC; k++) begin
          if (entValid[i] && !insSel[i] && !sqSel[i] && entWait[i][k]
              && !wakeHit[i][k] && (entTag[i][k] == insDstTag)) begin
            dupNow = 1'b1;
          end
        end
      end
    end
  end

  // Scoreboard: reallocation clears, completion sets.
  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_sb
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sbReady[r] <= 1'b1;
      end else if (strobes.dstTrack && (insDstTag == TAG_W'(r))) begin
        sbReady[r] <= 1'b0;
      end else if (strobes.cmpTrack && (cmpTag == TAG_W'(r))) begin
        sbReady[r] <= 1'b1;
      end
    end
  end

  // Slot state.
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entMem[i]   <= 1'b0;
        entWait[i]  <= '0;
        entTag[i]   <= '0;
      end else if (insSel[i]) begin
        entValid[i] <= 1'b1;
        entMem[i]   <= strobes.insMem;
        entWait[i]  <= insWait;
        entTag[i]   <= srcTag;
      end else if (sqSel[i]) begin
        entValid[i] <= 1'b0;
        entWait[i]  <= '0;
      end else begin
        entWait[i]  <= entWait[i] & ~wakeHit[i];
      end
    end

    assign issueReady[i]   = entValid[i] & ~entMem[i] & ~(|entWait[i]);
    assign memRegsReady[i] = entValid[i] &  entMem[i] & ~(|entWait[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dupQ <= 1'b0;
    else       dupQ <= dupNow;
  end

  assign dupErr = dupQ;

endmodule

// File: rtl/sbw_wakeup_unit.sv
module sbw_wakeup_unit
  import sbw_pkg::*;
#(
  parameter int NUM_PREGS   = 40,
  parameter int TAG_W       = 6,
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   insValid,
  input  logic [IDX_W-1:0]       insIdx,
  input  logic                   insSrc0Use,
  input  logic [TAG_W-1:0]       insSrc0Tag,
  input  logic                   insSrc0Rdy,
  input  logic                   insSrc1Use,
  input  logic [TAG_W-1:0]       insSrc1Tag,
  input  logic                   insSrc1Rdy,
  input  logic                   insDstUse,
  input  logic [TAG_W-1:0]       insDstTag,
  input  logic                   insIsMem,
  input  logic                   cmpValid,
  input  logic [TAG_W-1:0]       cmpTag,
  input  logic                   sqValid,
  input  logic [IDX_W-1:0]       sqIdx,
  output logic [NUM_ENTRIES-1:0] issueReady,
  output logic [NUM_ENTRIES-1:0] memRegsReady,
  output logic                   dupErr
);

  sbwStrobes_t                   strobes;
  logic [NUM_ENTRIES-1:0]        insSel;
  logic [NUM_ENTRIES-1:0]        sqSel;
  logic [NUM_SRC-1:0][TAG_W-1:0] srcTag;

  assign srcTag = {insSrc1Tag, insSrc0Tag};

  sbw_ctrl #(
    .NUM_PREGS  (NUM_PREGS),
    .TAG_W      (TAG_W),
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_ctrl (
    .insValid (insValid),
    .insIdx   (insIdx),
    .srcUse   ({insSrc1Use, insSrc0Use}),
    .srcRdy   ({insSrc1Rdy, insSrc0Rdy}),
    .srcTag   (srcTag),
    .insDstUse(insDstUse),
    .insDstTag(insDstTag),
    .insIsMem (insIsMem),
    .cmpValid (cmpValid),
    .cmpTag   (cmpTag),
    .sqValid  (sqValid),
    .sqIdx    (sqIdx),
    .strobes  (strobes),
    .insSel   (insSel),
    .sqSel    (sqSel)
  );

  sbw_datapath #(
    .NUM_PREGS  (NUM_PREGS),
    .TAG_W      (TAG_W),
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .insSel      (insSel),
    .sqSel       (sqSel),
    .srcTag      (srcTag),
    .insDstTag   (insDstTag),
    .cmpTag      (cmpTag),
    .issueReady  (issueReady),
    .memRegsReady(memRegsReady),
    .dupErr      (dupErr)
  );

endmodule

// File: rtl/sbw_wakeup_unit_chk.sv
module sbw_wakeup_unit_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   insValid,
  input logic [IDX_W-1:0]       insIdx,
  input logic                   insSrc0Use,
  input logic                   insSrc1Use,
  input logic                   insDstUse,
  input logic                   insIsMem,
  input logic                   sqValid,
  input logic [IDX_W-1:0]       sqIdx,
  input logic [NUM_ENTRIES-1:0] issueReady,
  input logic [NUM_ENTRIES-1:0] memRegsReady,
  input logic                   dupErr
);

  // R1: a reset cycle leaves both ready vectors empty.
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rstN |=> (issueReady == '0) && (memRegsReady == '0));

  // R9: a slot never shows on both vectors.
  assert_vectors_disjoint_R9: assert property (@(posedge clk) disable iff (!rstN)
    (issueReady & memRegsReady) == '0);

  // R10: a non-memory insert with no used sources is an issue candidate next cycle.
  assert_unused_src_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !insSrc0Use && !insSrc1Use && !insIsMem)
      |=> issueReady[$past(insIdx)]);

  // R8: a squash that no insert overrides empties the slot.
  assert_squash_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sqValid && !(insValid && (insIdx == sqIdx)))
      |=> !issueReady[$past(sqIdx)] && !memRegsReady[$past(sqIdx)]);

  // R4: with no insert and no squash, nothing that was ready drops.
  assert_ready_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!insValid && !sqValid)
      |=> ((($past(issueReady) | $past(memRegsReady)) & ~(issueReady | memRegsReady)) == '0));

  // R7: the error flag only follows an insert that writes a destination.
  assert_dup_follows_insert_R7: assert property (@(posedge clk) disable iff (!rstN)
    dupErr |-> $past(insValid && insDstUse));

endmodule

bind sbw_wakeup_unit sbw_wakeup_unit_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .IDX_W      (IDX_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .insValid    (insValid),
  .insIdx      (insIdx),
  .insSrc0Use  (insSrc0Use),
  .insSrc1Use  (insSrc1Use),
  .insDstUse   (insDstUse),
  .insIsMem    (insIsMem),
  .sqValid     (sqValid),
  .sqIdx       (sqIdx),
  .issueReady  (issueReady),
  .memRegsReady(memRegsReady),
  .dupErr      (dupErr)
);

// File: tb/sbw_wakeup_unit_tb.sv
`timescale 1ns/1ps
module sbw_wakeup_unit_tb;

  localparam int NUM_PREGS   = 40;
  localparam int TAG_W       = 6;
  localparam int NUM_ENTRIES = 8;
  localparam int IDX_W       = 3;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   insValid = 1'b0;
  logic [IDX_W-1:0]       insIdx = '0;
  logic                   insSrc0Use = 1'b0;
  logic [TAG_W-1:0]       insSrc0Tag = '0;
  logic                   insSrc0Rdy = 1'b0;
  logic                   insSrc1Use = 1'b0;
  logic [TAG_W-1:0]       insSrc1Tag = '0;
  logic                   insSrc1Rdy = 1'b0;
  logic                   insDstUse = 1'b0;
  logic [TAG_W-1:0]       insDstTag = '0;
  logic                   insIsMem = 1'b0;
  logic                   cmpValid = 1'b0;
  logic [TAG_W-1:0]       cmpTag = '0;
  logic                   sqValid = 1'b0;
  logic [IDX_W-1:0]       sqIdx = '0;
  logic [NUM_ENTRIES-1:0] issueReady;
  logic [NUM_ENTRIES-1:0] memRegsReady;
  logic                   dupErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sbw_wakeup_unit #(
    .NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W), .NUM_ENTRIES(NUM_ENTRIES)
  ) u_dut (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insIdx(insIdx),
    .insSrc0Use(insSrc0Use), .insSrc0Tag(insSrc0Tag), .insSrc0Rdy(insSrc0Rdy),
    .insSrc1Use(insSrc1Use), .insSrc1Tag(insSrc1Tag), .insSrc1Rdy(insSrc1Rdy),
    .insDstUse(insDstUse), .insDstTag(insDstTag), .insIsMem(insIsMem),
    .cmpValid(cmpValid), .cmpTag(cmpTag),
    .sqValid(sqValid), .sqIdx(sqIdx),
    .issueReady(issueReady), .memRegsReady(memRegsReady), .dupErr(dupErr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Inputs are set right after a falling edge; tick() passes one rising edge
  // and returns at the next falling edge with all strobes cleared.
  task automatic tick();
    @(negedge clk);
    insValid = 1'b0; insSrc0Use = 1'b0; insSrc1Use = 1'b0;
    insSrc0Rdy = 1'b0; insSrc1Rdy = 1'b0; insDstUse = 1'b0; insIsMem = 1'b0;
    cmpValid = 1'b0; sqValid = 1'b0;
  endtask

  task automatic setIns(input int idx,
                        input bit s0u, input int s0t, input bit s0r,
                        input bit s1u, input int s1t, input bit s1r,
                        input bit du, input int dt, input bit mem);
    insValid = 1'b1; insIdx = IDX_W'(idx);
    insSrc0Use = s0u; insSrc0Tag = TAG_W'(s0t); insSrc0Rdy = s0r;
    insSrc1Use = s1u; insSrc1Tag = TAG_W'(s1t); insSrc1Rdy = s1r;
    insDstUse = du; insDstTag = TAG_W'(dt); insIsMem = mem;
  endtask

  task automatic setCmp(input int t);
    cmpValid = 1'b1; cmpTag = TAG_W'(t);
  endtask

  task automatic setSq(input int idx);
    sqValid = 1'b1; sqIdx = IDX_W'(idx);
  endtask

  task automatic clearAll();
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      setSq(i); tick();
    end
    check("R8", "all slots empty after squash sweep",
          32'(issueReady | memRegsReady), 32'h0);
  endtask

  task automatic testReset();
    check("R1", "issueReady after reset", 32'(issueReady), 32'h0);
    check("R1", "memRegsReady after reset", 32'(memRegsReady), 32'h0);
    check("R1", "dupErr after reset", 32'(dupErr), 32'h0);
    setIns(0, 1, 5, 0, 1, 6, 0, 0, 0, 0); tick();
    check("R1", "scoreboard ready from reset", 32'(issueReady), 32'h01);
    clearAll();
  endtask

  task automatic testClearAndWake();
    setIns(1, 0, 0, 0, 0, 0, 0, 1, 10, 0); tick();
    check("R10", "slot with no sources ready", 32'(issueReady[1]), 32'h1);
    setIns(2, 1, 10, 0, 0, 0, 0, 0, 0, 0); tick();
    check("R2", "consumer of cleared tag waits", 32'(issueReady[2]), 32'h0);
    setIns(3, 0, 0, 0, 0, 0, 0, 1, 12, 0); tick();
    setIns(4, 0, 0, 0, 0, 0, 0, 1, 13, 0); tick();
    setIns(5, 1, 12, 0, 0, 0, 0, 0, 0, 0); tick();
    setIns(6, 1, 12, 0, 1, 13, 0, 0, 0, 0); tick();
    setIns(7, 0, 10, 0, 0, 0, 0, 0, 0, 0); tick();
    check("R10", "unused source with pending tag ignored", 32'(issueReady[7]), 32'h1);
    check("R2", "two-source consumer waits", 32'(issueReady[6:5]), 32'h0);
    setCmp(12); tick();
    check("R4", "single-source consumer woken", 32'(issueReady[5]), 32'h1);
    check("R4", "second tag still pending", 32'(issueReady[6]), 32'h0);
    check("R4", "other tag consumer untouched", 32'(issueReady[2]), 32'h0);
    setCmp(13); tick();
    check("R4", "two-source consumer woken", 32'(issueReady[6]), 32'h1);
    setCmp(10); tick();
    check("R4", "full vector after all wakeups", 32'(issueReady), 32'hFE);
    clearAll();
  endtask

  task automatic testBypassAndFlags();
    setIns(0, 0, 0, 0, 0, 0, 0, 1, 20, 0); tick();
    setIns(1, 1, 20, 0, 0, 0, 0, 0, 0, 0); setCmp(20); tick();
    check("R5", "insert during completion is ready", 32'(issueReady[1]), 32'h1);
    setIns(2, 1, 20, 0, 0, 0, 0, 0, 0, 0); tick();
    check("R3", "scoreboard set by completion", 32'(issueReady[2]), 32'h1);
    setIns(3, 0, 0, 0, 0, 0, 0, 1, 21, 0); tick();
    setIns(4, 1, 21, 1, 0, 0, 0, 0, 0, 0); tick();
    check("R3", "sender-ready flag honoured", 32'(issueReady[4]), 32'h1);
    clearAll();
  endtask

  task automatic testOutOfRange();
    setIns(0, 1, 50, 0, 0, 0, 0, 1, 45, 0); tick();
    check("R6", "out-of-range source ready", 32'(issueReady[0]), 32'h1);
    setIns(1, 1, 45, 0, 0, 0, 0, 0, 0, 0); tick();
    check("R6", "out-of-range destination cleared nothing", 32'(issueReady[1]), 32'h1);
    setIns(2, 0, 0, 0, 0, 0, 0, 1, 22, 0); tick();
    setIns(3, 1, 22, 0, 0, 0, 0, 0, 0, 0); tick();
    setCmp(62); tick();
    check("R6", "out-of-range completion wakes nothing", 32'(issueReady[3]), 32'h0);
    setIns(4, 0, 0, 0, 0, 0, 0, 1, 45, 0); tick();
    check("R6", "out-of-range reallocation no error", 32'(dupErr), 32'h0);
    setCmp(22); tick();
    check("R4", "in-range completion wakes", 32'(issueReady[3]), 32'h1);
    clearAll();
  endtask

  task automatic testDupProducer();
    setIns(0, 0, 0, 0, 0, 0, 0, 1, 25, 0); tick();
    setIns(1, 1, 25, 0, 0, 0, 0, 0, 0, 0); tick();
    check("R7", "no error before reallocation", 32'(dupErr), 32'h0);
    setIns(2, 0, 0, 0, 0, 0, 0, 1, 25, 0); tick();
    check("R7", "error on reallocation with waiter", 32'(dupErr), 32'h1);
    tick();
    check("R7", "error lasts one cycle", 32'(dupErr), 32'h0);
    setIns(3, 0, 0, 0, 0, 0, 0, 1, 26, 0); tick();
    check("R7", "no error without waiter", 32'(dupErr), 32'h0);
    clearAll();
  endtask

  task automatic testSquash();
    setIns(0, 0, 0, 0, 0, 0, 0, 1, 30, 0); tick();
    setIns(1, 1, 30, 0, 0, 0, 0, 0, 0, 0); tick();
    setIns(2, 0, 0, 0, 0, 0, 0, 0, 0, 0); tick();
    setSq(2); tick();
    check("R8", "squashed ready slot drops", 32'(issueReady[2]), 32'h0);
    setSq(1); tick();
    setCmp(30); tick();
    check("R8", "completion does not revive squashed slot", 32'(issueReady[1]), 32'h0);
    setIns(3, 0, 0, 0, 0, 0, 0, 1, 31, 0); tick();
    setIns(4, 1, 31, 0, 0, 0, 0, 0, 0, 0); tick();
    setSq(4); tick();
    setIns(5, 0, 0, 0, 0, 0, 0, 1, 31, 0); tick();
    check("R8", "squashed dependence not counted", 32'(dupErr), 32'h0);
    setIns(6, 0, 0, 0, 0, 0, 0, 0, 0, 0); setSq(6); tick();
    check("R8", "insert beats squash on same slot", 32'(issueReady[6]), 32'h1);
    clearAll();
  endtask

  task automatic testMem();
    setIns(4, 0, 0, 0, 0, 0, 0, 0, 0, 1); tick();
    check("R9", "memory slot on mem vector", 32'(memRegsReady[4]), 32'h1);
    check("R9", "memory slot not on issue vector", 32'(issueReady[4]), 32'h0);
    setIns(5, 0, 0, 0, 0, 0, 0, 1, 33, 0); tick();
    setIns(6, 1, 33, 0, 0, 0, 0, 0, 0, 1); tick();
    check("R9", "waiting memory slot not ready", 32'(memRegsReady[6]), 32'h0);
    setCmp(33); tick();
    check("R9", "woken memory slot on mem vector", 32'(memRegsReady[6]), 32'h1);
    check("R9", "issue vector excludes memory slots", 32'(issueReady), 32'h20);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClearAndWake();
    testBypassAndFlags();
    testOutOfRange();
    testDupProducer();
    testSquash();
    testMem();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule